// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block is the landing point for message-signalled interrupts. A device raises an interrupt by writing a small number to a memory address. The address picks one of 16 frames and, inside that frame, one of 8 index registers. The written value, from 0 to 15, picks which of that register's 16 vector bits becomes pending. The bank therefore holds 2048 pending bits, arranged by frame, then index register, then vector.

Each frame drives its own interrupt line, which is high while any vector in the frame is pending. Each frame also has a summary register with one bit per index register. A handler services a frame in three steps. It reads the summary. It then reads each flagged index register, lowest first. Each index read returns that register's pending vectors and clears them, so every vector is delivered once. A write that lands in the same cycle as the read that clears its register is kept, not lost.

The write port and the read port are single-cycle strobes. Read data appears on the cycle after the strobe and holds until the next read.

Top module: `msi_term_bank`

## Requirements
- R1: A write targets an index register when address bit 23 is 0 and bits [15:0] are 0. Bits [22:19] give the frame and bits [18:16] give the index register.
- R2: A write to an index register with data value v, where 0 <= v <= 15, sets vector bit v of that register pending.
- R3: A write is ignored and changes no state if its data value is 16 or more, if address bit 23 is 1, or if address bits [15:0] are not 0.
- R4: A read at address 0x800000 + (f << 16) returns the summary of frame f. Bit x, for x from 0 to 7, is 1 when index register x of frame f has any pending vector. Bits [31:8] read 0, and the read changes no state.
- R5: irq[f] is 1 from the clock edge that makes any vector of frame f pending, and stays 1 until no vector of frame f is pending.
- R6: A read of an index register returns its 16 pending bits in rd_data[15:0], with rd_data[31:16] = 0. The same edge clears exactly those bits.
- R7: If a write sets a vector in an index register in the same cycle that a read clears that register, the written vector is pending after the edge.
- R8: rd_data is valid on the cycle after rd_valid and holds its value until the next read.
- R9: While rst_n is low, all pending bits are cleared, irq is 0 and rd_data is 0.
- R10: A read of any address that is neither an index register nor a summary register returns 0 and changes no state. This includes addresses with bit 23 set and a nonzero value in bits [22:20].
- R11: Writes to different vectors and registers accumulate. Each stays pending until the index read that returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe, one cycle per message |
| wr_addr | input | 24 | Write address |
| wr_data | input | 32 | Write data; its value selects the vector |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | 24 | Read address |
| rd_data | output | 32 | Read result, valid one cycle after rd_valid |
| irq | output | 16 | One interrupt line per frame |

## Verification
The main sweep visits every (frame, index, vector) combination with a single write. For each one, the bench checks:
- that exactly the right interrupt line rises;
- that the summary flags exactly the right index register;
- that the index read returns exactly the right vector bit and leaves the frame quiet.

This sweep tells apart any mix-up of the address fields or the data decode. Multi-vector patterns show that pending bits accumulate and that each index read clears only its own register. Out-of-range data values, misaligned addresses and summary-space writes must leave the bank idle. A write that collides with the read clearing the same register must survive. Repeated summary reads and unmapped reads must not disturb pending state.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
    // Every register starts at the beginning of its own 64 KiB region
    localparam int REGION_LSB = 16;
    localparam int BUS_DW     = 32;

    typedef enum logic [1:0] {
        RD_NONE    = 2'd0,
        RD_INDEX   = 2'd1,
        RD_SUMMARY = 2'd2
    } rd_kind_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_term_pkg::*;
#(
    parameter int FW     = 4,
    parameter int IW     = 3,
    parameter int FRAMES = 16,
    parameter int ADDR_W = REGION_LSB + IW + FW + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              idx_hit,
    output logic              sum_hit,
    output logic [FW-1:0]     frame,
    output logic [IW-1:0]     idx,
    output logic [FW-1:0]     sum_frame
);
    localparam int FRAME_LSB = REGION_LSB + IW;
    localparam int SUM_BIT   = ADDR_W - 1;
    localparam int SUM_TOP   = REGION_LSB + FW;

    logic low_zero;
    logic sum_pad_zero;

    always_comb begin
        low_zero     = (addr[REGION_LSB-1:0] == '0);
        idx          = addr[FRAME_LSB-1:REGION_LSB];
        frame        = addr[SUM_BIT-1:FRAME_LSB];
        sum_frame    = addr[SUM_TOP-1:REGION_LSB];
        sum_pad_zero = (addr[SUM_BIT-1:SUM_TOP] == '0);
        idx_hit      = !addr[SUM_BIT] && low_zero && (int'(frame) < FRAMES);
        sum_hit      = addr[SUM_BIT] && low_zero && sum_pad_zero
                       && (int'(sum_frame) < FRAMES);
    end
endmodule

// File: rtl/msi_frame.sv
module msi_frame #(
    parameter int ROWS = 8,
    parameter int VEC  = 16,
    localparam int IW  = $clog2(ROWS),
    localparam int VW  = $clog2(VEC),
    localparam int NB  = ROWS * VEC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic [VW-1:0]   set_vec,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    output logic [NB-1:0]   pend_o,
    output logic [ROWS-1:0] summary_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NB-1:0] pend;
    } frame_state_t;

    frame_state_t st_d, st_q;
    logic [NB-1:0] set_mask, clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_en) set_mask[int'(set_idx)*VEC + int'(set_vec)] = 1'b1;
        if (clr_en) clr_mask[int'(clr_idx)*VEC +: VEC] = '1;
        st_d = st_q;
        // clear first, then set: a colliding message survives
        st_d.pend = (st_q.pend & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int r = 0; r < ROWS; r++)
            summary_o[r] = |st_q.pend[r*VEC +: VEC];
        irq_o  = |summary_o;
        pend_o = st_q.pend;
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> st_q.pend[int'($past(set_idx))*VEC + int'($past(set_vec))]);

    assert_clear_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> (st_q.pend[int'($past(clr_idx))*VEC +: VEC] == '0));
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
    import msi_term_pkg::*;
#(
    parameter int FRAMES  = 16,
    parameter int ROWS    = 8,
    parameter int VEC     = 16,
    localparam int FW     = $clog2(FRAMES),
    localparam int IW     = $clog2(ROWS),
    localparam int ADDR_W = REGION_LSB + IW + FW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_DW-1:0] rd_data,
    output logic [FRAMES-1:0] irq
);
    localparam int VW = $clog2(VEC);
    localparam int NB = ROWS * VEC;

    typedef struct packed {
        logic [BUS_DW-1:0] rdata;
    } rd_state_t;

    logic          w_idx_hit, w_sum_hit, r_idx_hit, r_sum_hit;
    logic [FW-1:0] w_frame, w_sum_frame, r_frame, r_sum_frame;
    logic [IW-1:0] w_idx, r_idx;
    logic          wr_ok;
    logic [VW-1:0] wr_vec;
    rd_kind_e      rd_kind;

    logic [FRAMES-1:0][NB-1:0]   pend_all;
    logic [FRAMES-1:0][ROWS-1:0] sum_all;

    rd_state_t rd_d, rd_q;

    msi_addr_decode #(.FW(FW), .IW(IW), .FRAMES(FRAMES), .ADDR_W(ADDR_W)) u_wdec (
        .addr(wr_addr), .idx_hit(w_idx_hit), .sum_hit(w_sum_hit),
        .frame(w_frame), .idx(w_idx), .sum_frame(w_sum_frame)
    );

    msi_addr_decode #(.FW(FW), .IW(IW), .FRAMES(FRAMES), .ADDR_W(ADDR_W)) u_rdec (
        .addr(rd_addr), .idx_hit(r_idx_hit), .sum_hit(r_sum_hit),
        .frame(r_frame), .idx(r_idx), .sum_frame(r_sum_frame)
    );

    always_comb begin
        wr_ok  = wr_valid && w_idx_hit && (wr_data < BUS_DW'(VEC));
        wr_vec = wr_data[VW-1:0];
        if (!rd_valid)      rd_kind = RD_NONE;
        else if (r_idx_hit) rd_kind = RD_INDEX;
        else if (r_sum_hit) rd_kind = RD_SUMMARY;
        else                rd_kind = RD_NONE;
    end

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        msi_frame #(.ROWS(ROWS), .VEC(VEC)) u_frame (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_en    (wr_ok && (w_frame == FW'(f))),
            .set_idx   (w_idx),
            .set_vec   (wr_vec),
            .clr_en    ((rd_kind == RD_INDEX) && (r_frame == FW'(f))),
            .clr_idx   (r_idx),
            .pend_o    (pend_all[f]),
            .summary_o (sum_all[f]),
            .irq_o     (irq[f])
        );
    end

    always_comb begin
        rd_d = rd_q;
        case (rd_kind)
            RD_INDEX: begin
                rd_d.rdata = '0;
                rd_d.rdata[VEC-1:0] = pend_all[r_frame][int'(r_idx)*VEC +: VEC];
            end
            RD_SUMMARY: begin
                rd_d.rdata = '0;
                rd_d.rdata[ROWS-1:0] = sum_all[r_sum_frame];
            end
            default: if (rd_valid) rd_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.rdata;

    assert_idle_keeps_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !rd_valid) |=> $stable(irq));

    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !r_idx_hit && !r_sum_hit) |=> (rd_data == '0));

    assert_summary_read_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && r_sum_hit && !r_idx_hit && !wr_valid) |=> $stable(irq));
endmodule

// File: tb/msi_term_bank_bench.sv
module msi_term_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    msi_term_bank u_msi_term_bank (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ia(input int f, input int i);
        return 24'((f << 19) | (i << 16));
    endfunction

    function automatic logic [23:0] sa(input int f);
        return 24'(32'h80_0000 | (f << 16));
    endfunction

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        d = rd_data;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        chk("R9 irq in reset", 32'(irq), 32'h0);
        chk("R9 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;

        // R1 R2 R4 R5 R6: full sweep of frame, index, vector
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 8; i++)
                for (int v = 0; v < 16; v++) begin
                    wr(ia(f, i), 32'(v));
                    chk("R5 irq after write", 32'(irq), 32'(1 << f));
                    rd(sa(f), d);
                    chk("R4 summary", d, 32'(1 << i));
                    rd(ia(f, i), d);
                    chk("R1 R2 R6 index read", d, 32'(1 << v));
                    chk("R6 cleared after read", 32'(irq), 32'h0);
                end

        // R11 accumulation
        wr(ia(3, 2), 0); wr(ia(3, 2), 5); wr(ia(3, 2), 15); wr(ia(3, 7), 9);
        chk("R11 irq", 32'(irq), 32'h8);
        rd(sa(3), d);  chk("R11 summary", d, 32'h84);
        rd(sa(3), d);  chk("R4 summary repeat no side effect", d, 32'h84);
        rd(ia(3, 2), d); chk("R11 index 2", d, 32'h8021);
        rd(sa(3), d);  chk("R6 only own row cleared", d, 32'h80);
        chk("R8 rd_data holds", rd_data, 32'h80);
        rd(ia(3, 7), d); chk("R11 index 7", d, 32'h200);
        chk("R5 irq drops", 32'(irq), 32'h0);

        // R3 ignored writes
        wr(ia(1, 0), 16);
        wr(ia(1, 0), 32'hFFFF_FFFF);
        wr(24'h08_0004, 1);
        wr(sa(1), 1);
        wr(24'h80_0000, 2);
        chk("R3 irq untouched", 32'(irq), 32'h0);
        rd(ia(1, 0), d); chk("R3 index empty", d, 32'h0);
        rd(sa(1), d);    chk("R3 summary empty", d, 32'h0);
        rd(ia(0, 0), d); chk("R3 frame0 empty", d, 32'h0);

        // R10 unmapped reads
        wr(ia(0, 0), 3);
        rd(24'h90_0000, d); chk("R10 unmapped high", d, 32'h0);
        rd(24'h00_0010, d); chk("R10 misaligned", d, 32'h0);
        chk("R10 irq kept", 32'(irq), 32'h1);
        rd(ia(0, 0), d); chk("R10 no side effect", d, 32'h8);

        // R7 collision of clearing read and write
        wr(ia(2, 1), 4);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = ia(2, 1);
        wr_valid = 1'b1; wr_addr = ia(2, 1); wr_data = 6;
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        chk("R7 R8 read before set", rd_data, 32'h10);
        chk("R7 irq kept", 32'(irq), 32'h4);
        rd(ia(2, 1), d); chk("R7 colliding write survives", d, 32'h40);

        // R9 reset mid-run
        wr(ia(9, 4), 7); wr(ia(15, 0), 1);
        chk("R5 two frames", 32'(irq), 32'h8200);
        rd(sa(9), d);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R9 irq cleared", 32'(irq), 32'h0);
        chk("R9 rd_data cleared", rd_data, 32'h0);
        rst_n = 1'b1;
        rd(ia(9, 4), d); chk("R9 pending cleared", d, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule